// File: doc/BRIEF.md
# Pipelined Program Counter Sequencer

This block produces the instruction fetch address for a small 8-bit controller core whose fetch and execute stages overlap. Every instruction cycle is four system clocks long. During a cycle the core executes the word fetched in the previous cycle while the word at `fetch_addr` is being fetched. At the last clock of each cycle the sequencer samples the control request that the decoder raised for the executing word and picks the next fetch address.

Any request that redirects the flow discards the word already fetched. Such requests are a jump, a call, a return, a taken skip, a write to the low address byte and an interrupt entry. The cycle that follows is a dummy cycle, and `flush` marks it. A four-entry return stack holds the addresses for subroutine and interrupt returns. The low eight address bits can be read back at any time, which serves a register-mapped view of the program counter.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `fetch_addr`=0, `phase`=0, `stack_depth`=0 and `flush`=1. The first cycle after reset is therefore a dummy cycle that fetches address 0.
- R2: `phase` counts 0,1,2,3,0,… once per clock, and `cycle_end` is high in phase 3. `fetch_addr` and `flush` change only on the clock edge that ends phase 3.
- R3: A cycle with no redirect advances `fetch_addr` by one, wrapping from 7FFh to 000h. "No redirect" means: not a dummy cycle, `ctl_op` is 0 or an unused code (6 or 7), and no interrupt is pending.
- R4: A jump request (`ctl_op`=1) loads `ctl_target` and starts a dummy cycle.
- R5: A skip request (`ctl_op`=4) discards the word just fetched. The next cycle is a dummy cycle that fetches `fetch_addr`+1.
- R6: A low-byte write (`ctl_op`=5) sets `fetch_addr[7:0]` to `pcl_wdata` and keeps `fetch_addr[10:8]`. It also starts a dummy cycle. `pcl_rdata` always equals `fetch_addr[7:0]`.
- R7: A call (`ctl_op`=2) pushes the current `fetch_addr` and loads `ctl_target`. A return (`ctl_op`=3) loads the most recently pushed address. Both start a dummy cycle.
- R8: `stack_depth` never exceeds 4. A push while 4 entries are held overwrites the oldest entry, and later returns give back the newest four addresses.
- R9: A return while `stack_depth` is 0 reloads the address produced by the last successful return, or 0 if no return has succeeded since reset.
- R10: An interrupt is accepted only at the end of a non-dummy cycle whose `ctl_op` is 0, 6 or 7. It pushes the current `fetch_addr` and loads 004h for `irq_ext`, or 008h for `irq_tmr` alone; `irq_ext` wins when both are high. A jump or other request in that cycle takes precedence, and the interrupt waits.
- R11: At the end of a dummy cycle, `ctl_op`, `irq_ext` and `irq_tmr` are ignored. `fetch_addr` advances by one and `flush` drops.
- R12: `flush` is high for exactly one instruction cycle (four clocks) after each redirect, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_op | input | 3 | Decoder request for the executing word: 0 none, 1 jump, 2 call, 3 return, 4 skip, 5 low-byte write |
| ctl_target | input | 11 | Jump or call destination |
| pcl_wdata | input | 8 | New low address byte for `ctl_op`=5 |
| irq_ext | input | 1 | External interrupt request (level) |
| irq_tmr | input | 1 | Timer interrupt request (level) |
| fetch_addr | output | 11 | Address fetched in the current instruction cycle |
| pcl_rdata | output | 8 | Low byte of the program counter |
| phase | output | 2 | Position inside the instruction cycle |
| cycle_end | output | 1 | High in the last phase of the instruction cycle |
| flush | output | 1 | Current cycle is a dummy cycle; the executing word is discarded |
| stack_depth | output | 3 | Number of valid return-stack entries |

## Verification
The bench uses the default parameters: an 11-bit counter, a four-level stack and four phases. With an 11-bit counter, a jump near the top of the space lets a few sequential cycles reach the wrap to zero, and a low-byte write near a page edge shows that the upper bits are kept. With only four stack levels, five nested calls are enough to overwrite the oldest entry, and the fifth return then reaches the empty-stack reload. Four phases keep each instruction cycle short, so the bench can compare every clock against its model while stepping through the whole control sequence.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_JUMP  = 3'd1,
        OP_CALL  = 3'd2,
        OP_RET   = 3'd3,
        OP_SKIP  = 3'd4,
        OP_LOWWR = 3'd5
    } ctl_op_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic redirect;
    } seq_act_t;

    function automatic ctl_op_e decode_op(input logic [2:0] raw);
        case (raw)
            3'd1:    return OP_JUMP;
            3'd2:    return OP_CALL;
            3'd3:    return OP_RET;
            3'd4:    return OP_SKIP;
            3'd5:    return OP_LOWWR;
            default: return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pcseq_phase.sv
module pcseq_phase #(
    parameter int PHASES = 4,
    localparam int PH_W = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase_o,
    output logic            last_o
);
    logic [PH_W-1:0] phase_q;

    assign last_o  = (phase_q == PH_W'(PHASES - 1));
    assign phase_o = phase_q;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (last_o)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/pcseq_stack.sv
module pcseq_stack #(
    parameter int W     = 11,
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [W-1:0]     push_val_i,
    output logic [W-1:0]     top_o,
    output logic [CNT_W-1:0] depth_o
);
    logic [W-1:0]     slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic [W-1:0]     last_pop;

    function automatic logic [PTR_W-1:0] ring_up(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] ring_down(input logic [PTR_W-1:0] p);
        return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
    endfunction

    assign rd_ptr  = ring_down(wr_ptr);
    assign top_o   = (count != '0) ? slot[rd_ptr] : last_pop;
    assign depth_o = count;

    always_ff @(posedge clk) begin
        if (push_i)
            slot[wr_ptr] <= push_val_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            count    <= '0;
            last_pop <= '0;
        end else if (push_i) begin
            wr_ptr <= ring_up(wr_ptr);
            if (count != CNT_W'(DEPTH))
                count <= count + 1'b1;
        end else if (pop_i && count != '0) begin
            wr_ptr   <= rd_ptr;
            count    <= count - 1'b1;
            last_pop <= slot[rd_ptr];
        end
    end
endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
    import pcseq_pkg::*;
#(
    parameter int PC_W  = 11,
    parameter int LOW_W = 8,
    parameter logic [PC_W-1:0] EXT_VEC = 'h004,
    parameter logic [PC_W-1:0] TMR_VEC = 'h008
) (
    input  logic [PC_W-1:0]  pc_i,
    input  logic             dummy_i,
    input  logic [2:0]       op_raw_i,
    input  logic [PC_W-1:0]  target_i,
    input  logic [LOW_W-1:0] low_i,
    input  logic             irq_ext_i,
    input  logic             irq_tmr_i,
    input  logic [PC_W-1:0]  stack_top_i,
    output logic [PC_W-1:0]  next_pc_o,
    output seq_act_t         act_o
);
    ctl_op_e op;

    always_comb begin
        op        = decode_op(op_raw_i);
        next_pc_o = pc_i + 1'b1;
        act_o     = '0;
        if (!dummy_i) begin
            if (op == OP_NONE) begin
                if (irq_ext_i || irq_tmr_i) begin
                    act_o.push     = 1'b1;
                    act_o.redirect = 1'b1;
                    next_pc_o      = irq_ext_i ? EXT_VEC : TMR_VEC;
                end
            end else begin
                act_o.redirect = 1'b1;
                case (op)
                    OP_JUMP:  next_pc_o = target_i;
                    OP_CALL: begin
                        act_o.push = 1'b1;
                        next_pc_o  = target_i;
                    end
                    OP_RET: begin
                        act_o.pop = 1'b1;
                        next_pc_o = stack_top_i;
                    end
                    OP_LOWWR: next_pc_o = {pc_i[PC_W-1:LOW_W], low_i};
                    default:  next_pc_o = pc_i + 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter int PC_W        = 11,
    parameter int LOW_W       = 8,
    parameter int STACK_DEPTH = 4,
    parameter int PHASES      = 4,
    parameter logic [PC_W-1:0] EXT_VEC = 'h004,
    parameter logic [PC_W-1:0] TMR_VEC = 'h008
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [2:0]                           ctl_op,
    input  logic [PC_W-1:0]                      ctl_target,
    input  logic [LOW_W-1:0]                     pcl_wdata,
    input  logic                                 irq_ext,
    input  logic                                 irq_tmr,
    output logic [PC_W-1:0]                      fetch_addr,
    output logic [LOW_W-1:0]                     pcl_rdata,
    output logic [$clog2(PHASES)-1:0]            phase,
    output logic                                 cycle_end,
    output logic                                 flush,
    output logic [$clog2(STACK_DEPTH+1)-1:0]     stack_depth
);
    logic [PC_W-1:0] pc_q;
    logic            dummy_q;
    logic            last;
    logic [PC_W-1:0] next_pc;
    logic [PC_W-1:0] stack_top;
    seq_act_t        act;

    pcseq_phase #(.PHASES(PHASES)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .phase_o (phase),
        .last_o  (last)
    );

    pcseq_next #(
        .PC_W(PC_W), .LOW_W(LOW_W), .EXT_VEC(EXT_VEC), .TMR_VEC(TMR_VEC)
    ) u_next (
        .pc_i        (pc_q),
        .dummy_i     (dummy_q),
        .op_raw_i    (ctl_op),
        .target_i    (ctl_target),
        .low_i       (pcl_wdata),
        .irq_ext_i   (irq_ext),
        .irq_tmr_i   (irq_tmr),
        .stack_top_i (stack_top),
        .next_pc_o   (next_pc),
        .act_o       (act)
    );

    pcseq_stack #(.W(PC_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk        (clk),
        .rst        (rst),
        .push_i     (last && act.push),
        .pop_i      (last && act.pop),
        .push_val_i (pc_q),
        .top_o      (stack_top),
        .depth_o    (stack_depth)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            dummy_q <= 1'b1;
        end else if (last) begin
            pc_q    <= next_pc;
            dummy_q <= act.redirect;
        end
    end

    assign fetch_addr = pc_q;
    assign pcl_rdata  = pc_q[LOW_W-1:0];
    assign flush      = dummy_q;
    assign cycle_end  = last;
endmodule

// File: rtl/pcseq_checker.sv
module pcseq_checker
    import pcseq_pkg::*;
#(
    parameter int PC_W        = 11,
    parameter int LOW_W       = 8,
    parameter int STACK_DEPTH = 4,
    parameter int PHASES      = 4,
    parameter logic [PC_W-1:0] EXT_VEC = 'h004
) (
    input logic                             clk,
    input logic                             rst,
    input logic [2:0]                       ctl_op,
    input logic [PC_W-1:0]                  ctl_target,
    input logic [LOW_W-1:0]                 pcl_wdata,
    input logic                             irq_ext,
    input logic                             irq_tmr,
    input logic [PC_W-1:0]                  fetch_addr,
    input logic [$clog2(PHASES)-1:0]        phase,
    input logic                             cycle_end,
    input logic                             flush,
    input logic [$clog2(STACK_DEPTH+1)-1:0] stack_depth
);
    localparam int PH_W = $clog2(PHASES);

    logic plain_op;
    assign plain_op = (decode_op(ctl_op) == OP_NONE);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (fetch_addr == '0 && flush && phase == '0 && stack_depth == '0)); // R1

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        !cycle_end |=> phase == PH_W'($past(phase) + 1'b1)); // R2

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cycle_end |=> ($stable(fetch_addr) && $stable(flush))); // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (cycle_end && !flush && plain_op && !irq_ext && !irq_tmr)
        |=> (fetch_addr == PC_W'($past(fetch_addr) + 1'b1) && !flush)); // R3

    AST_JUMP_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cycle_end && !flush && ctl_op == OP_JUMP)
        |=> (fetch_addr == $past(ctl_target) && flush)); // R4

    AST_SKIP_DROP: assert property (@(posedge clk) disable iff (rst)
        (cycle_end && !flush && ctl_op == OP_SKIP)
        |=> (fetch_addr == PC_W'($past(fetch_addr) + 1'b1) && flush)); // R5

    AST_LOW_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cycle_end && !flush && ctl_op == OP_LOWWR)
        |=> (fetch_addr == {$past(fetch_addr[PC_W-1:LOW_W]), $past(pcl_wdata)} && flush)); // R6

    AST_CALL_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cycle_end && !flush && ctl_op == OP_CALL)
        |=> (fetch_addr == $past(ctl_target) && flush && stack_depth != '0)); // R7

    AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (rst)
        stack_depth <= ($clog2(STACK_DEPTH+1))'(STACK_DEPTH)); // R8

    AST_IRQ_EXT: assert property (@(posedge clk) disable iff (rst)
        (cycle_end && !flush && plain_op && irq_ext)
        |=> (fetch_addr == EXT_VEC && flush)); // R10

    AST_DUMMY_END: assert property (@(posedge clk) disable iff (rst)
        (cycle_end && flush)
        |=> (fetch_addr == PC_W'($past(fetch_addr) + 1'b1) && !flush)); // R11

    AST_FLUSH_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(flush) |-> $past(cycle_end)); // R12
endmodule

bind pc_sequencer pcseq_checker #(
    .PC_W(PC_W), .LOW_W(LOW_W), .STACK_DEPTH(STACK_DEPTH),
    .PHASES(PHASES), .EXT_VEC(EXT_VEC)
) u_pcseq_checker (
    .clk         (clk),
    .rst         (rst),
    .ctl_op      (ctl_op),
    .ctl_target  (ctl_target),
    .pcl_wdata   (pcl_wdata),
    .irq_ext     (irq_ext),
    .irq_tmr     (irq_tmr),
    .fetch_addr  (fetch_addr),
    .phase       (phase),
    .cycle_end   (cycle_end),
    .flush       (flush),
    .stack_depth (stack_depth)
);

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
    localparam int MASK = 'h7FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  ctl_op = '0;
    logic [10:0] ctl_target = '0;
    logic [7:0]  pcl_wdata = '0;
    logic        irq_ext = 1'b0;
    logic        irq_tmr = 1'b0;
    logic [10:0] fetch_addr;
    logic [7:0]  pcl_rdata;
    logic [1:0]  phase;
    logic        cycle_end;
    logic        flush;
    logic [2:0]  stack_depth;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    int m_pc, m_ph, m_fl, m_last;
    int m_stk[$];

    always #4 clk = ~clk;

    pc_sequencer u_pc_sequencer (
        .clk(clk), .rst(rst), .ctl_op(ctl_op), .ctl_target(ctl_target),
        .pcl_wdata(pcl_wdata), .irq_ext(irq_ext), .irq_tmr(irq_tmr),
        .fetch_addr(fetch_addr), .pcl_rdata(pcl_rdata), .phase(phase),
        .cycle_end(cycle_end), .flush(flush), .stack_depth(stack_depth)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_pc = 0; m_ph = 0; m_fl = 1; m_last = 0;
        m_stk.delete();
    endfunction

    function automatic void model_push(input int v);
        if (m_stk.size() == 4) void'(m_stk.pop_front());
        m_stk.push_back(v);
    endfunction

    function automatic void model_step();
        int op;
        if (m_ph == 3) begin
            op = int'(ctl_op);
            if (op > 5) op = 0;
            if (m_fl != 0) begin
                m_pc = (m_pc + 1) & MASK;
                m_fl = 0;
            end else if (op == 0 && (irq_ext || irq_tmr)) begin
                model_push(m_pc);
                m_pc = irq_ext ? 'h004 : 'h008;
                m_fl = 1;
            end else if (op == 0) begin
                m_pc = (m_pc + 1) & MASK;
            end else begin
                m_fl = 1;
                case (op)
                    1: m_pc = int'(ctl_target);
                    2: begin model_push(m_pc); m_pc = int'(ctl_target); end
                    3: begin
                        if (m_stk.size() > 0) m_last = m_stk.pop_back();
                        m_pc = m_last;
                    end
                    4: m_pc = (m_pc + 1) & MASK;
                    default: m_pc = (m_pc & 'h700) | int'(pcl_wdata);
                endcase
            end
        end
        m_ph = (m_ph + 1) % 4;
    endfunction

    task automatic compare_all();
        chk("R3 fetch_addr", int'(fetch_addr), m_pc);
        chk("R12 flush", int'(flush), m_fl);
        chk("R2 phase", int'(phase), m_ph);
        chk("R2 cycle_end", int'(cycle_end), (m_ph == 3) ? 1 : 0);
        chk("R8 stack_depth", int'(stack_depth), m_stk.size());
        chk("R6 pcl_rdata", int'(pcl_rdata), m_pc & 'hFF);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic cyc(input int op, input int tgt, input int low, input bit e, input bit t);
        ctl_op = 3'(op); ctl_target = 11'(tgt); pcl_wdata = 8'(low);
        irq_ext = e; irq_tmr = t;
        for (int k = 0; k < 4; k++) tick();
        ctl_op = '0; irq_ext = 1'b0; irq_tmr = 1'b0;
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset addr", int'(fetch_addr), 0);
        chk("R1 reset flush", int'(flush), 1);
        chk("R1 reset phase", int'(phase), 0);
        chk("R1 reset depth", int'(stack_depth), 0);
        rst = 1'b0;

        cyc(1, 'h300, 0, 1, 0);
        chk("R11 dummy ignores jump/irq", int'(fetch_addr), 'h001);
        chk("R11 depth untouched", int'(stack_depth), 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R3 sequential", int'(fetch_addr), 'h003);
        cyc(7, 'h123, 0, 0, 0);
        chk("R3 unused code acts as none", int'(fetch_addr), 'h004);

        cyc(1, 'h0FE, 0, 0, 0);
        chk("R4 jump target", int'(fetch_addr), 'h0FE);
        chk("R4 jump flush", int'(flush), 1);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R3 page crossing", int'(fetch_addr), 'h101);

        cyc(5, 0, 'h34, 0, 0);
        chk("R6 low write keeps page", int'(fetch_addr), 'h134);
        chk("R6 low readback", int'(pcl_rdata), 'h34);
        cyc(0, 0, 0, 0, 0);

        cyc(4, 0, 0, 0, 0);
        chk("R5 skip dummy fetch", int'(fetch_addr), 'h136);
        chk("R5 skip flush", int'(flush), 1);
        cyc(0, 0, 0, 0, 0);
        chk("R5 after skip", int'(fetch_addr), 'h137);

        for (int i = 0; i < 5; i++) begin
            cyc(2, 'h200 + 'h10 * i, 0, 0, 0);
            chk("R7 call target", int'(fetch_addr), 'h200 + 'h10 * i);
            cyc(0, 0, 0, 0, 0);
        end
        chk("R8 depth saturates", int'(stack_depth), 4);

        cyc(3, 0, 0, 0, 0);
        chk("R7 return newest", int'(fetch_addr), 'h231);
        cyc(0, 0, 0, 0, 0);
        cyc(3, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(3, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(3, 0, 0, 0, 0);
        chk("R8 oldest overwritten", int'(fetch_addr), 'h201);
        chk("R8 stack empty", int'(stack_depth), 0);
        cyc(0, 0, 0, 0, 0);
        cyc(3, 0, 0, 0, 0);
        chk("R9 empty return reloads", int'(fetch_addr), 'h201);
        cyc(0, 0, 0, 0, 0);
        chk("R9 resume", int'(fetch_addr), 'h202);

        cyc(0, 0, 0, 1, 1);
        chk("R10 external wins", int'(fetch_addr), 'h004);
        chk("R10 pushed", int'(stack_depth), 1);
        cyc(0, 0, 0, 0, 0);
        cyc(3, 0, 0, 0, 0);
        chk("R10 return to interrupted", int'(fetch_addr), 'h202);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 1);
        chk("R10 timer vector", int'(fetch_addr), 'h008);
        cyc(0, 0, 0, 0, 0);
        cyc(3, 0, 0, 0, 0);
        chk("R10 timer return", int'(fetch_addr), 'h203);
        cyc(0, 0, 0, 0, 0);
        cyc(1, 'h050, 0, 1, 0);
        chk("R10 jump beats irq", int'(fetch_addr), 'h050);
        chk("R10 irq not taken", int'(stack_depth), 0);
        cyc(0, 0, 0, 1, 0);
        chk("R11 irq held off in dummy", int'(fetch_addr), 'h051);
        chk("R11 irq no push", int'(stack_depth), 0);

        cyc(1, 'h7FE, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R3 wrap to zero", int'(fetch_addr), 'h000);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule